// File: doc/BRIEF.md
# Deferred-Fault Poison Tracker

This block sits beside an architectural register file and holds one poison flag per register. It lets a compiler hoist instructions above branches without changing the program's exception behaviour. A speculated instruction that hits a terminating exception does not trap. It marks its destination register as poisoned. Speculated consumers of a poisoned register pass the mark on to their own destinations. The trap is taken only when a non-speculative instruction, or any store, reads a poisoned register.

Each cycle the block accepts at most one issued instruction. The instruction carries two source indices with enables, a destination index with a write enable, a speculative flag, a store flag and a terminating-exception flag. The fault indication is combinational and appears in the same cycle as the issue. Poison updates take effect at the next clock edge.

For context switches, the whole vector is always visible on an output. A save command clears the vector after the operating system has read it. A restore command loads a vector back into the flags. Register 0 always reads as unpoisoned.

Top module: `poison_tracker`

## Requirements
- R1: After synchronous reset every poison flag is 0 and `fault` is low.
- R2: The flag of register 0 never becomes 1. Writes to index 0 and bit 0 of a restored vector are ignored.
- R3: A valid, speculative, non-store instruction with `iss_wr_en` set updates its destination flag at the next edge. The new value is `iss_term` OR any poisoned enabled source. A speculative instruction never raises `fault`.
- R4: A source is looked at only when its enable (`iss_rd_a_en` or `iss_rd_b_en`) is 1. A poisoned source whose enable is 0 neither propagates poison nor causes a fault.
- R5: A valid non-speculative instruction that reads a poisoned enabled source raises `fault` in the same cycle. `fault_reg` gives that source's index. When both sources are poisoned, source A is reported. With no fault, `fault_reg` is 0.
- R6: A non-speculative write that neither faults nor has `iss_term` set clears its destination flag. A faulting or terminating non-speculative instruction leaves the destination flag unchanged.
- R7: A store (`iss_store`=1) is treated as non-speculative whatever `iss_spec` says. It faults when its address operand (source A) or its data operand (source B) is poisoned. It never changes any flag, even with `iss_wr_en` set.
- R8: `poison_bits` shows the current vector, with bit i belonging to register i. `ctx_save` clears every flag at the next edge.
- R9: `ctx_restore` loads `ctx_restore_bits` (bit i to register i) at the next edge. It takes priority over a simultaneous `ctx_save`.
- R10: In a cycle with `ctx_save` or `ctx_restore` set, the issued instruction's poison update is dropped. Its fault is still reported.
- R11: With no valid issue and no context command, all flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_spec | input | 1 | Instruction was moved speculatively |
| iss_store | input | 1 | Instruction is a store |
| iss_term | input | 1 | Instruction raised a terminating exception |
| iss_rd_a_en | input | 1 | Source A is read (store address) |
| iss_src_a | input | IDX_W | Source A register index |
| iss_rd_b_en | input | 1 | Source B is read (store data) |
| iss_src_b | input | IDX_W | Source B register index |
| iss_wr_en | input | 1 | Instruction writes a destination |
| iss_dst | input | IDX_W | Destination register index |
| ctx_save | input | 1 | Clear all flags after read-out |
| ctx_restore | input | 1 | Load flags from `ctx_restore_bits` |
| ctx_restore_bits | input | NUM_REGS | Vector to restore |
| poison_bits | output | NUM_REGS | Current poison vector |
| fault | output | 1 | Deferred exception is taken now |
| fault_reg | output | IDX_W | Index of the poisoned source that faulted |

## Verification
The bench builds the block with `NUM_REGS` = 8. With that size, every register index can be walked through a poison-then-consume sequence. The whole vector also fits in one readable byte for exact save and restore comparisons. Pattern 8'hA5 checks that bit 0 is masked on restore. The simultaneous save/restore cases and the context-command-with-issue cases check the ordering of the update paths.

// File: rtl/poison_pkg.sv
package poison_pkg;

    typedef struct packed {
        logic valid;
        logic spec;
        logic store;
        logic term;
        logic rd_a;
        logic rd_b;
        logic wr;
    } iss_flags_t;

    typedef enum logic [1:0] {
        CTX_NONE    = 2'd0,
        CTX_SAVE    = 2'd1,
        CTX_RESTORE = 2'd2
    } ctx_op_e;

    // Restore outranks save; either outranks an issue update.
    function automatic ctx_op_e decode_ctx(input logic save, input logic restore);
        if (restore)   return CTX_RESTORE;
        else if (save) return CTX_SAVE;
        else           return CTX_NONE;
    endfunction

    // Stores never behave speculatively.
    function automatic logic treat_spec(input iss_flags_t f);
        return f.spec && !f.store;
    endfunction

endpackage

// File: rtl/poison_src_check.sv
module poison_src_check
    import poison_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] cur_bits,
    input  iss_flags_t          flags,
    input  logic [IDX_W-1:0]    src_a,
    input  logic [IDX_W-1:0]    src_b,
    output logic                src_hit,
    output logic                fault,
    output logic [IDX_W-1:0]    fault_reg
);
    logic hit_a;
    logic hit_b;

    always_comb begin
        hit_a   = flags.rd_a && cur_bits[src_a];
        hit_b   = flags.rd_b && cur_bits[src_b];
        src_hit = hit_a || hit_b;
        fault   = flags.valid && !treat_spec(flags) && src_hit;
        if (!fault)     fault_reg = '0;
        else if (hit_a) fault_reg = src_a;
        else            fault_reg = src_b;
    end
endmodule

// File: rtl/poison_next.sv
module poison_next
    import poison_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] cur_bits,
    input  iss_flags_t          flags,
    input  logic [IDX_W-1:0]    dst,
    input  logic                src_hit,
    input  logic                fault,
    input  ctx_op_e             ctx,
    input  logic [NUM_REGS-1:0] restore_bits,
    output logic [NUM_REGS-1:0] nxt_bits
);
    logic wr_here_any;

    assign wr_here_any = flags.valid && flags.wr && !flags.store;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
        if (i == 0) begin : g_zero
            assign nxt_bits[i] = 1'b0;
        end else begin : g_live
            logic b;
            always_comb begin
                b = cur_bits[i];
                if (ctx == CTX_RESTORE) begin
                    b = restore_bits[i];
                end else if (ctx == CTX_SAVE) begin
                    b = 1'b0;
                end else if (wr_here_any && dst == IDX_W'(i)) begin
                    if (treat_spec(flags))
                        b = flags.term || src_hit;
                    else if (!fault && !flags.term)
                        b = 1'b0;
                end
            end
            assign nxt_bits[i] = b;
        end
    end
endmodule

// File: rtl/poison_tracker.sv
module poison_tracker
    import poison_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                iss_valid,
    input  logic                iss_spec,
    input  logic                iss_store,
    input  logic                iss_term,
    input  logic                iss_rd_a_en,
    input  logic [IDX_W-1:0]    iss_src_a,
    input  logic                iss_rd_b_en,
    input  logic [IDX_W-1:0]    iss_src_b,
    input  logic                iss_wr_en,
    input  logic [IDX_W-1:0]    iss_dst,
    input  logic                ctx_save,
    input  logic                ctx_restore,
    input  logic [NUM_REGS-1:0] ctx_restore_bits,
    output logic [NUM_REGS-1:0] poison_bits,
    output logic                fault,
    output logic [IDX_W-1:0]    fault_reg
);
    iss_flags_t          flags;
    ctx_op_e             ctx;
    logic                src_hit;
    logic [NUM_REGS-1:0] nxt_bits;
    logic [NUM_REGS-1:0] state_q;

    always_comb begin
        flags.valid = iss_valid;
        flags.spec  = iss_spec;
        flags.store = iss_store;
        flags.term  = iss_term;
        flags.rd_a  = iss_rd_a_en;
        flags.rd_b  = iss_rd_b_en;
        flags.wr    = iss_wr_en;
        ctx         = decode_ctx(ctx_save, ctx_restore);
    end

    poison_src_check #(.NUM_REGS(NUM_REGS)) u_check (
        .cur_bits  (state_q),
        .flags     (flags),
        .src_a     (iss_src_a),
        .src_b     (iss_src_b),
        .src_hit   (src_hit),
        .fault     (fault),
        .fault_reg (fault_reg)
    );

    poison_next #(.NUM_REGS(NUM_REGS)) u_next (
        .cur_bits     (state_q),
        .flags        (flags),
        .dst          (iss_dst),
        .src_hit      (src_hit),
        .fault        (fault),
        .ctx          (ctx),
        .restore_bits (ctx_restore_bits),
        .nxt_bits     (nxt_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= nxt_bits;
    end

    assign poison_bits = state_q;
endmodule

// File: rtl/poison_tracker_chk.sv
module poison_tracker_chk #(
    parameter int NUM_REGS = 32,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst,
    input logic                iss_valid,
    input logic                iss_spec,
    input logic                iss_store,
    input logic                iss_term,
    input logic                iss_wr_en,
    input logic [IDX_W-1:0]    iss_dst,
    input logic                ctx_save,
    input logic                ctx_restore,
    input logic [NUM_REGS-1:0] ctx_restore_bits,
    input logic [NUM_REGS-1:0] poison_bits,
    input logic                fault,
    input logic [IDX_W-1:0]    fault_reg
);
    // R2
    zero_reg_clean_chk: assert property (@(posedge clk) disable iff (rst)
        !poison_bits[0]);

    // R3
    spec_term_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_spec && !iss_store && iss_term && iss_wr_en &&
         iss_dst != '0 && !ctx_save && !ctx_restore)
        |=> poison_bits[$past(iss_dst)]);

    // R3
    spec_never_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_spec && !iss_store) |-> !fault);

    // R5
    fault_needs_issue_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> iss_valid);

    // R5
    quiet_reg_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !fault |-> fault_reg == '0);

    // R8
    save_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx_save && !ctx_restore) |=> poison_bits == '0);

    // R9
    restore_loads_chk: assert property (@(posedge clk) disable iff (rst)
        ctx_restore |=> poison_bits == ($past(ctx_restore_bits) & ~NUM_REGS'(1)));

    // R11
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!iss_valid && !ctx_save && !ctx_restore) |=> $stable(poison_bits));
endmodule

bind poison_tracker poison_tracker_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .iss_valid        (iss_valid),
    .iss_spec         (iss_spec),
    .iss_store        (iss_store),
    .iss_term         (iss_term),
    .iss_wr_en        (iss_wr_en),
    .iss_dst          (iss_dst),
    .ctx_save         (ctx_save),
    .ctx_restore      (ctx_restore),
    .ctx_restore_bits (ctx_restore_bits),
    .poison_bits      (poison_bits),
    .fault            (fault),
    .fault_reg        (fault_reg)
);

// File: tb/sim_poison_tracker.sv
module sim_poison_tracker;
    localparam int N = 8;
    localparam int W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic v = 0, sp = 0, st = 0, tm = 0, ae = 0, be = 0, we = 0, sv = 0, rs = 0;
    logic [W-1:0] sa = '0, sb = '0, ds = '0;
    logic [N-1:0] rv = '0;
    logic [N-1:0] bits;
    logic         flt;
    logic [W-1:0] freg;

    always #10 clk = ~clk;

    poison_tracker #(.NUM_REGS(N)) u0 (
        .clk(clk), .rst(rst), .iss_valid(v), .iss_spec(sp), .iss_store(st),
        .iss_term(tm), .iss_rd_a_en(ae), .iss_src_a(sa), .iss_rd_b_en(be),
        .iss_src_b(sb), .iss_wr_en(we), .iss_dst(ds), .ctx_save(sv),
        .ctx_restore(rs), .ctx_restore_bits(rv), .poison_bits(bits),
        .fault(flt), .fault_reg(freg)
    );

    typedef struct {
        logic         f;
        logic [W-1:0] r;
        logic [N-1:0] b;
        string        req;
    } exp_t;

    exp_t q[$];
    logic [N-1:0] mdl = '0;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic drive(input logic iv, isp, ist, itm, iae, input logic [W-1:0] isa,
                         input logic ibe, input logic [W-1:0] isb, input logic iwe,
                         input logic [W-1:0] ids, input logic isv, irs,
                         input logic [N-1:0] irv, input string req);
        exp_t e;
        logic ha, hb, es, fx;
        @(negedge clk);
        v = iv; sp = isp; st = ist; tm = itm; ae = iae; sa = isa; be = ibe;
        sb = isb; we = iwe; ds = ids; sv = isv; rs = irs; rv = irv;
        ha = iae && mdl[isa];
        hb = ibe && mdl[isb];
        es = isp && !ist;
        fx = iv && !es && (ha || hb);
        e.f = fx;
        e.r = !fx ? '0 : (ha ? isa : isb);
        e.b = mdl;
        e.req = req;
        q.push_back(e);
        if (irs)      mdl = irv & ~N'(1);
        else if (isv) mdl = '0;
        else if (iv && iwe && !ist && ids != '0) begin
            if (es)              mdl[ids] = itm || ha || hb;
            else if (!fx && !itm) mdl[ids] = 1'b0;
        end
    endtask

    task automatic idle(input string req);
        drive(0,0,0,0,0,0,0,0,0,0,0,0,'0,req);
    endtask

    // monitor: compare expectations a quarter period after inputs change
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (bits !== e.b) begin
                    fails++;
                    $display("FAIL %s poison_bits actual=%h expected=%h", e.req, bits, e.b);
                end
                checks++;
                if (flt !== e.f || freg !== e.r) begin
                    fails++;
                    $display("FAIL %s fault/reg actual=%b/%0d expected=%b/%0d",
                             e.req, flt, freg, e.f, e.r);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle("R1");
        //   v sp st tm ae sa be sb we ds sv rs rv
        drive(1,1,0,1, 0,0, 0,0, 1,3, 0,0,'0, "R3");
        drive(1,1,0,0, 1,3, 0,0, 1,5, 0,0,'0, "R4");
        drive(1,1,0,0, 0,0, 0,3, 1,6, 0,0,'0, "R4");
        drive(1,1,0,1, 0,0, 0,0, 1,0, 0,0,'0, "R2");
        drive(1,0,0,0, 1,5, 0,0, 1,3, 0,0,'0, "R5");
        drive(1,0,0,0, 1,3, 1,5, 1,2, 0,0,'0, "R5");
        drive(1,0,0,0, 1,1, 1,5, 0,0, 0,0,'0, "R5");
        drive(1,0,0,0, 1,1, 1,2, 1,5, 0,0,'0, "R6");
        drive(1,0,0,1, 1,1, 0,0, 1,3, 0,0,'0, "R6");
        drive(1,1,1,0, 1,3, 1,1, 0,0, 0,0,'0, "R7");
        drive(1,0,1,0, 1,1, 1,3, 0,0, 0,0,'0, "R7");
        drive(1,1,1,1, 1,1, 1,2, 1,4, 0,0,'0, "R7");
        idle("R11");
        drive(0,0,0,0, 0,0, 0,0, 0,0, 1,0,'0, "R8");
        idle("R8");
        drive(0,0,0,0, 0,0, 0,0, 0,0, 0,1,8'hA5, "R9");
        idle("R2");
        drive(0,0,0,0, 0,0, 0,0, 0,0, 1,1,8'h0F, "R9");
        drive(1,0,0,0, 1,2, 0,0, 1,2, 0,1,8'h30, "R10");
        drive(1,1,0,1, 0,0, 0,0, 1,1, 1,0,'0, "R10");
        idle("R11");
        idle("R11");
        for (int i = 1; i < N; i++) begin
            drive(1,1,0,1, 0,0, 0,0, 1,W'(i), 0,0,'0, "R3");
            drive(1,0,0,0, 0,0, 1,W'(i), 1,W'(i), 0,0,'0, "R5");
            drive(1,0,0,0, 0,0, 0,0, 1,W'(i), 0,0,'0, "R6");
        end
        idle("R11");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule